// File: doc/BRIEF.md
# Interrupt Sequencer With Shadow Context

This block controls interrupt entry and exit for a small 8-bit processor core. It watches two interrupt sources. The first is an internal 8-bit counter that advances on every clock and raises an interrupt when it wraps, if its enable input is high. The second is a one-cycle request pulse from an external port edge unit. All sources share one priority level. When the block accepts an interrupt, it saves the live program counter into a one-entry interrupt stack, which is kept apart from the subroutine call stack. It also copies the working, status and file-select registers into shadow registers. It then asks the core to load the fetch address with the vector.

When the core signals a return from the handler, the block asks the core to load the saved program counter. The shadow registers keep presenting the saved W, STATUS and FSR values, so the core can restore them. The block then clears the global mask. A second form of return also writes an 8-bit literal into the counter. The handler finds out which source fired by polling. The counter keeps no pending flag, and an external pulse that arrives while the mask is set is held until the mask clears.

Top module: `irq_ctx_seq`

## Requirements
- R1: While reset is low and in the first cycle after it, irq_masked is 0, vec_load is 0, w_out, status_out and fsr_out are 0, and tmr_value is 0 during reset.
- R2: If the mask is clear and a request is present, then one cycle later vec_load is 1, vec_ret is 0, vec_addr is 0 and irq_masked is 1. In that same cycle w_out, status_out and fsr_out show the values w_in, status_in and fsr_in had in the accepting cycle. vec_load lasts one cycle.
- R3: While irq_masked is 1, no request causes vec_load. The shadow outputs and the saved program counter do not change.
- R4: If ret_stb is high while masked, then one cycle later vec_load is 1, vec_ret is 1, vec_addr equals the program counter saved at entry, and irq_masked is 0. The shadow outputs still hold the values saved at entry.
- R5: An ext_req pulse that arrives while masked is held. It is accepted in the first cycle after the return, so vec_load with vec_ret 0 appears two cycles after the return strobe.
- R6: A return with ret_lit set makes tmr_value equal lit_val in the cycle after the strobe, and counting continues from there. A return with ret_lit clear lets the counter advance by one.
- R7: tmr_value rises by one every cycle and wraps from 0xFF to 0x00. If tmr_irq_en is 1 and the mask is clear, the wrap causes an entry: vec_load appears in the same cycle that tmr_value first reads 0x00.
- R8: A wrap while tmr_irq_en is 0 causes no entry.
- R9: ret_stb while unmasked is ignored. There is no vec_load and no literal load, so the counter just advances.
- R10: A counter wrap and an ext_req pulse in the same cycle cause exactly one entry. After the return no second entry follows.
- R11: A counter wrap while masked is not kept. After the return no entry follows from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_irq_en | input | 1 | Enable for the counter-wrap interrupt |
| ext_req | input | 1 | One-cycle external interrupt request pulse |
| pc_in | input | PC_W | Live program counter |
| w_in | input | 8 | Live working register |
| status_in | input | 8 | Live status register |
| fsr_in | input | 8 | Live file-select register |
| ret_stb | input | 1 | Return-from-interrupt strobe |
| ret_lit | input | 1 | Return also loads the counter with lit_val |
| lit_val | input | 8 | Literal for the counter |
| vec_load | output | 1 | One-cycle request to load fetch address vec_addr |
| vec_ret | output | 1 | The load is a return restore (1) or an entry (0) |
| vec_addr | output | PC_W | Vector on entry, saved program counter on return |
| w_out | output | 8 | Shadow working register |
| status_out | output | 8 | Shadow status register |
| fsr_out | output | 8 | Shadow file-select register |
| tmr_value | output | 8 | Current counter value |
| irq_masked | output | 1 | Global interrupt mask, set while in a handler |

## Verification
The hardest cases to reach are the ones where a counter wrap falls in a chosen cycle. These are a wrap that coincides with an external pulse, a wrap while the mask is set, and a wrap with the enable off. The counter runs on its own from reset, so the stimulus first enters a handler through an external pulse. It then returns with a literal near 0xFF, which puts the wrap a known number of cycles ahead. The bench counts those cycles to place the external pulse or the mask state exactly on the wrap.

// File: rtl/irq_ctx_pkg.sv
// Shared widths and types for the interrupt sequencer.
// Assumes an 8-bit data path; context fields are stored as an indexed array.
package irq_ctx_pkg;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned N_FIELD = 3;
    localparam int unsigned F_W      = 0;
    localparam int unsigned F_STATUS = 1;
    localparam int unsigned F_FSR    = 2;

    typedef logic [N_FIELD-1:0][DATA_W-1:0] ctx_t;

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_ENTER  = 2'd1,
        EV_RETURN = 2'd2
    } ev_e;
endpackage

// File: rtl/irq_tick_timer.sv
// Free-running counter with a literal load port.
// Counts every clock; a load takes precedence over counting and suppresses
// the wrap indication for that cycle. Assumes synchronous active-low reset.
module irq_tick_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Wrap occurs when the all-ones value is about to increment.
    always_comb begin
        wrap = (&cnt) && !load_en;
    end

    // Counter register: load or increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load_en) begin
            cnt <= load_val;
        end else begin
            cnt <= cnt + ONE;
        end
    end
endmodule

// File: rtl/irq_accept_ctl.sv
// Accept/return control: global mask, held external request, event output.
// Assumes ext_req is a pulse; it is held internally until an entry is taken.
// The counter wrap has no hold and is dropped when it cannot be taken.
module irq_accept_ctl
    import irq_ctx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tmr_wrap,
    input  logic tmr_irq_en,
    input  logic ext_req,
    input  logic ret_stb,
    output logic masked,
    output logic take,
    output logic ret_ok,
    output ev_e  ev_q
);
    logic ext_hold;
    logic any_req;

    // Decide whether an entry or a return happens this cycle.
    always_comb begin
        any_req = (tmr_wrap && tmr_irq_en) || ext_hold || ext_req;
        take    = !masked && any_req;
        ret_ok  = masked && ret_stb;
    end

    // Global mask and held external request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            masked   <= 1'b0;
            ext_hold <= 1'b0;
        end else begin
            if (take) begin
                masked <= 1'b1;
            end else if (ret_ok) begin
                masked <= 1'b0;
            end
            ext_hold <= (ext_hold || ext_req) && !take;
        end
    end

    // Registered event for the vector-load stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q <= EV_NONE;
        end else if (take) begin
            ev_q <= EV_ENTER;
        end else if (ret_ok) begin
            ev_q <= EV_RETURN;
        end else begin
            ev_q <= EV_NONE;
        end
    end
endmodule

// File: rtl/irq_ctx_store.sv
// One-entry interrupt PC stack and shadow context registers.
// Captures on push only; contents stay on the outputs until the next push.
module irq_ctx_store
    import irq_ctx_pkg::*;
#(
    parameter int unsigned PC_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [PC_W-1:0] pc_in,
    input  ctx_t            ctx_in,
    output logic [PC_W-1:0] pc_saved,
    output ctx_t            ctx_saved
);
    // Saved program counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_saved <= '0;
        end else if (push) begin
            pc_saved <= pc_in;
        end
    end

    // One shadow register per context field.
    for (genvar gi = 0; gi < N_FIELD; gi++) begin : g_shadow
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctx_saved[gi] <= '0;
            end else if (push) begin
                ctx_saved[gi] <= ctx_in[gi];
            end
        end
    end
endmodule

// File: rtl/irq_ctx_seq.sv
// Interrupt sequencer top: timer, accept control, context store and the
// registered vector-load stage. Entry and return each produce a one-cycle
// vec_load one clock after the deciding cycle.
module irq_ctx_seq
    import irq_ctx_pkg::*;
#(
    parameter int unsigned PC_W     = 11,
    parameter int unsigned VEC_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_irq_en,
    input  logic              ext_req,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [DATA_W-1:0] w_in,
    input  logic [DATA_W-1:0] status_in,
    input  logic [DATA_W-1:0] fsr_in,
    input  logic              ret_stb,
    input  logic              ret_lit,
    input  logic [DATA_W-1:0] lit_val,
    output logic              vec_load,
    output logic              vec_ret,
    output logic [PC_W-1:0]   vec_addr,
    output logic [DATA_W-1:0] w_out,
    output logic [DATA_W-1:0] status_out,
    output logic [DATA_W-1:0] fsr_out,
    output logic [DATA_W-1:0] tmr_value,
    output logic              irq_masked
);
    localparam logic [PC_W-1:0] VEC_PC = PC_W'(VEC_ADDR);

    logic            tmr_wrap;
    logic            take;
    logic            ret_ok;
    logic            lit_load;
    ev_e             ev_q;
    ctx_t            ctx_live;
    ctx_t            ctx_saved;
    logic [PC_W-1:0] pc_saved;

    // Gather the live context into the field array.
    always_comb begin
        ctx_live           = '0;
        ctx_live[F_W]      = w_in;
        ctx_live[F_STATUS] = status_in;
        ctx_live[F_FSR]    = fsr_in;
        lit_load           = ret_ok && ret_lit;
    end

    irq_tick_timer #(.CNT_W(DATA_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (lit_load),
        .load_val (lit_val),
        .cnt      (tmr_value),
        .wrap     (tmr_wrap)
    );

    irq_accept_ctl ctl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tmr_wrap   (tmr_wrap),
        .tmr_irq_en (tmr_irq_en),
        .ext_req    (ext_req),
        .ret_stb    (ret_stb),
        .masked     (irq_masked),
        .take       (take),
        .ret_ok     (ret_ok),
        .ev_q       (ev_q)
    );

    irq_ctx_store #(.PC_W(PC_W)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (take),
        .pc_in     (pc_in),
        .ctx_in    (ctx_live),
        .pc_saved  (pc_saved),
        .ctx_saved (ctx_saved)
    );

    // Vector address register: vector on entry, saved PC on return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_addr <= '0;
        end else if (take) begin
            vec_addr <= VEC_PC;
        end else if (ret_ok) begin
            vec_addr <= pc_saved;
        end
    end

    // Decode the registered event into the load strobes.
    always_comb begin
        vec_load   = (ev_q != EV_NONE);
        vec_ret    = (ev_q == EV_RETURN);
        w_out      = ctx_saved[F_W];
        status_out = ctx_saved[F_STATUS];
        fsr_out    = ctx_saved[F_FSR];
    end
endmodule

// File: rtl/irq_ctx_seq_chk.sv
// Checker for the interrupt sequencer, attached by bind.
module irq_ctx_seq_chk #(
    parameter int unsigned PC_W = 11
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ret_stb,
    input logic            ret_lit,
    input logic [7:0]      lit_val,
    input logic            vec_load,
    input logic            vec_ret,
    input logic [PC_W-1:0] vec_addr,
    input logic [7:0]      w_out,
    input logic [7:0]      tmr_value,
    input logic            irq_masked
);
    AST_ENTRY_SETS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_masked) |-> (vec_load && !vec_ret && vec_addr == '0)); // R2

    AST_NO_LOAD_WHILE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_masked && $past(irq_masked)) |-> !vec_load); // R3

    AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_masked && $past(irq_masked)) |-> $stable(w_out)); // R3

    AST_RETURN_UNMASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_load && vec_ret) |-> !irq_masked); // R4

    AST_LIT_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_stb && ret_lit && irq_masked) |=> (tmr_value == $past(lit_val))); // R6

    AST_RET_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_stb && !irq_masked) |=> !(vec_load && vec_ret)); // R9
endmodule

bind irq_ctx_seq irq_ctx_seq_chk #(.PC_W(PC_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ret_stb    (ret_stb),
    .ret_lit    (ret_lit),
    .lit_val    (lit_val),
    .vec_load   (vec_load),
    .vec_ret    (vec_ret),
    .vec_addr   (vec_addr),
    .w_out      (w_out),
    .tmr_value  (tmr_value),
    .irq_masked (irq_masked)
);

// File: tb/irq_ctx_seq_tb_top.sv
`timescale 1ns/1ps
module irq_ctx_seq_tb_top;
    localparam int unsigned PC_W = 11;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tmr_irq_en = 1'b0;
    logic            ext_req = 1'b0;
    logic [PC_W-1:0] pc_in = '0;
    logic [7:0]      w_in = '0;
    logic [7:0]      status_in = '0;
    logic [7:0]      fsr_in = '0;
    logic            ret_stb = 1'b0;
    logic            ret_lit = 1'b0;
    logic [7:0]      lit_val = '0;
    logic            vec_load;
    logic            vec_ret;
    logic [PC_W-1:0] vec_addr;
    logic [7:0]      w_out;
    logic [7:0]      status_out;
    logic [7:0]      fsr_out;
    logic [7:0]      tmr_value;
    logic            irq_masked;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    irq_ctx_seq #(.PC_W(PC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tmr_irq_en(tmr_irq_en), .ext_req(ext_req),
        .pc_in(pc_in), .w_in(w_in), .status_in(status_in), .fsr_in(fsr_in),
        .ret_stb(ret_stb), .ret_lit(ret_lit), .lit_val(lit_val),
        .vec_load(vec_load), .vec_ret(vec_ret), .vec_addr(vec_addr),
        .w_out(w_out), .status_out(status_out), .fsr_out(fsr_out),
        .tmr_value(tmr_value), .irq_masked(irq_masked)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Advance one clock and sample 1 ns after the edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Enter through an external pulse with the given live context.
    task automatic enter_ext(input logic [PC_W-1:0] pc, input logic [7:0] w,
                             input logic [7:0] s, input logic [7:0] f);
        pc_in = pc; w_in = w; status_in = s; fsr_in = f; ext_req = 1'b1;
        tick();
        ext_req = 1'b0;
    endtask

    task automatic do_return(input logic lit, input logic [7:0] val);
        ret_stb = 1'b1; ret_lit = lit; lit_val = val;
        tick();
        ret_stb = 1'b0; ret_lit = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        chk("R1", "masked in reset", irq_masked, 0);
        chk("R1", "vec_load in reset", vec_load, 0);
        chk("R1", "timer in reset", tmr_value, 0);
        chk("R1", "shadows in reset", {w_out, status_out, fsr_out}, 0);
        rst_n = 1'b1;
        tick();
        chk("R1", "masked after reset", irq_masked, 0);
        chk("R1", "vec_load after reset", vec_load, 0);
    endtask

    task automatic t_entry_and_hold();
        enter_ext(11'h123, 8'hA5, 8'h3C, 8'h81);
        chk("R2", "vec_load on entry", vec_load, 1);
        chk("R2", "vec_ret on entry", vec_ret, 0);
        chk("R2", "vector address", vec_addr, 0);
        chk("R2", "mask set", irq_masked, 1);
        chk("R2", "shadows captured", {w_out, status_out, fsr_out}, 24'hA53C81);
        tick();
        chk("R2", "vec_load is a pulse", vec_load, 0);
        // Pulse while masked: must be held, not taken.
        enter_ext(11'h7FF, 8'h11, 8'h22, 8'h33);
        chk("R3", "no entry while masked", vec_load, 0);
        repeat (3) tick();
        chk("R3", "still no entry", vec_load, 0);
        chk("R3", "shadows unchanged", {w_out, status_out, fsr_out}, 24'hA53C81);
    endtask

    task automatic t_return_and_reentry();
        pc_in = 11'h055;
        do_return(1'b1, 8'h40);
        chk("R4", "vec_load on return", vec_load, 1);
        chk("R4", "vec_ret on return", vec_ret, 1);
        chk("R4", "restored pc", vec_addr, 11'h123);
        chk("R4", "mask cleared", irq_masked, 0);
        chk("R4", "shadows restored", {w_out, status_out, fsr_out}, 24'hA53C81);
        chk("R6", "literal loaded", tmr_value, 8'h40);
        tick();
        chk("R5", "held request taken", vec_load, 1);
        chk("R5", "held request is entry", vec_ret, 0);
        chk("R5", "masked again", irq_masked, 1);
        chk("R6", "counts from literal", tmr_value, 8'h41);
        do_return(1'b0, 8'hEE);
        chk("R4", "second return pc", vec_addr, 11'h055);
        chk("R6", "plain return advances", tmr_value, 8'h42);
        tick();
        chk("R5", "no extra entry", vec_load, 0);
    endtask

    task automatic t_ret_unmasked();
        logic [7:0] prev;
        prev = tmr_value;
        do_return(1'b1, 8'h99);
        chk("R9", "no load on stray return", vec_load, 0);
        chk("R9", "no literal on stray return", tmr_value, 8'(prev + 8'd1));
    endtask

    task automatic t_timer_entry();
        enter_ext(11'h010, 8'h01, 8'h02, 8'h03);
        chk("R7", "setup entry", vec_load, 1);
        tmr_irq_en = 1'b1;
        pc_in = 11'h2AA;
        do_return(1'b1, 8'hFD);
        chk("R7", "preload FD", tmr_value, 8'hFD);
        tick();
        chk("R7", "at FE no entry", vec_load, 0);
        tick();
        chk("R7", "at FF", tmr_value, 8'hFF);
        chk("R7", "at FF no entry", vec_load, 0);
        tick();
        chk("R7", "wrapped to 00", tmr_value, 8'h00);
        chk("R7", "wrap entry", vec_load, 1);
        chk("R7", "wrap entry masked", irq_masked, 1);
    endtask

    task automatic t_wrap_masked();
        repeat (260) tick();
        chk("R11", "still masked", irq_masked, 1);
        chk("R11", "timer 04", tmr_value, 8'h04);
        tmr_irq_en = 1'b0;
        do_return(1'b0, 8'h00);
        chk("R11", "return pc", vec_addr, 11'h2AA);
        tick();
        chk("R11", "lost wrap not taken", vec_load, 0);
    endtask

    task automatic t_wrap_disabled();
        int bad = 0;
        int saw_zero = 0;
        for (int i = 0; i < 300; i++) begin
            tick();
            if (vec_load !== 1'b0) bad++;
            if (tmr_value == 8'h00) saw_zero++;
        end
        chk("R8", "no entry with enable low", bad, 0);
        chk("R8", "wrap did happen", (saw_zero > 0), 1);
    endtask

    task automatic t_simultaneous();
        enter_ext(11'h100, 8'h00, 8'h00, 8'h00);
        tmr_irq_en = 1'b1;
        do_return(1'b1, 8'hFE);
        tick();
        chk("R10", "at FF", tmr_value, 8'hFF);
        ext_req = 1'b1;
        tick();
        ext_req = 1'b0;
        chk("R10", "one entry", vec_load, 1);
        tmr_irq_en = 1'b0;
        tick();
        chk("R10", "single pulse", vec_load, 0);
        do_return(1'b0, 8'h00);
        chk("R10", "return", vec_ret, 1);
        tick();
        chk("R10", "no second entry", vec_load, 0);
        chk("R10", "unmasked", irq_masked, 0);
    endtask

    initial begin
        t_reset();
        t_entry_and_hold();
        t_return_and_reentry();
        t_ret_unmasked();
        t_timer_entry();
        t_wrap_masked();
        t_wrap_disabled();
        t_simultaneous();
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end
endmodule